// File: doc/BRIEF.md
# Address Watch and Wait Unit

This unit lets one processor thread place a watch on a single aligned memory region and then sleep until that region is written by another agent, or until an interrupt, fault or translation-invalidate event arrives. An arm command latches the watched address. A later wait command either stalls the thread or, when the watch has already fired, completes at once. The watch does not restart by itself when a wait completes. Only a new arm command restarts it, so software must check its flag location again after every wake.

Other bus agents' writes are snooped. A write can fire the watch only when it carries the write-back memory-type flag and falls in the same granule as the latched address. Software writes the granule size through a small register port. The legal lower and upper sizes can be read on two constant outputs. Both commands need privilege level 0. At any other level they raise a one-cycle fault pulse and change nothing.

Top module: `addr_watch_unit`

## Requirements
- R1: An arm or wait command presented while `cpl` is not 0, and while `stall` is low, produces `cmd_fault` high for exactly the next cycle. It does not change the watch state and does not produce a wake.
- R2: An arm command at level 0 with `arm_wb`=1 latches `arm_addr` and puts the watch in the armed state. A following wait command raises `stall` in the cycle after it is sampled.
- R3: An arm command with `arm_wb`=0 leaves the watch unarmed. Later snooped writes to that address do not fire it, and a wait then stalls until an event arrives.
- R4: While stalled and armed, a snooped write with `snp_valid`=1 and `snp_wb`=1 whose address matches the latched address above the granule bits ends the stall. `wake_pulse` rises one cycle later with reason 2'b00. Writes without `snp_wb`, and writes outside the granule, are ignored.
- R5: When a wait is issued with the watch already fired, `stall` stays low. `wake_pulse` rises in the next cycle with the reason code that fired the watch.
- R6: A completed wait does not re-arm the watch. A second wait without a new arm completes immediately.
- R7: While stalled, `ev_intr` wakes the thread with reason 2'b01 and `ev_fault` wakes it with reason 2'b10, one cycle later.
- R8: `ev_inval` wakes a stalled thread with reason 2'b11. When the watch is armed and the thread is not stalled, it fires the watch so that the next wait completes at once with reason 2'b11.
- R9: `ev_pwr` neither ends a stall nor clears a fired watch.
- R10: When several wake sources coincide, the reported reason follows the priority write (00), then fault (10), then interrupt (01), then invalidate (11).
- R11: A write to the granule register stores the requested byte size clamped to [`gran_min`, `gran_max`] and rounded down to a power of two. The result is readable on `gran_size` from the next cycle. After reset the granule equals `gran_min`. The region match uses the current granule.
- R12: Arm and wait commands presented while `stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl | input | PLW | Current privilege level of the thread |
| arm_valid | input | 1 | Arm command strobe |
| arm_addr | input | AW | Address to watch |
| arm_wb | input | 1 | Arm address is write-back memory type |
| wait_valid | input | 1 | Wait command strobe |
| snp_valid | input | 1 | Snooped write from another agent |
| snp_addr | input | AW | Snooped write address |
| snp_wb | input | 1 | Snooped write is write-back memory type |
| ev_intr | input | 1 | Interrupt-class event (maskable, NMI, SMI, INIT, machine check) |
| ev_fault | input | 1 | Fault or abort event |
| ev_inval | input | 1 | Translation-invalidate event |
| ev_pwr | input | 1 | Power-management event (throttle, stop-clock) |
| gran_wr | input | 1 | Granule register write strobe |
| gran_wdata | input | LW | Requested granule size in bytes |
| gran_size | output | LW | Current granule size in bytes |
| gran_min | output | LW | Smallest legal granule size |
| gran_max | output | LW | Largest legal granule size |
| stall | output | 1 | Thread is sleeping in a wait |
| wake_pulse | output | 1 | One-cycle wait-completion pulse |
| wake_reason | output | 2 | Reason code, valid with `wake_pulse` |
| cmd_fault | output | 1 | One-cycle pulse for a command refused at nonzero privilege |

## Verification
Every result of this unit lands exactly one clock after the edge that samples its cause. That holds for `stall` rising after a wait, `wake_pulse` with its reason after a hit or event, or at once for a wait on a fired watch, `cmd_fault` after a refused command, and `gran_size` after a register write. The bench changes inputs just after a falling edge and reads outputs at the following falling edge, so each check sits one rising edge after its stimulus. Wake pulses are matched in order against expected reasons that are queued before the causing edge. A pulse with nothing queued, or a queued reason left unmatched, counts as a failure.

// File: rtl/awu_pkg.sv
package awu_pkg;

  typedef enum logic [1:0] {
    RSN_WRITE = 2'b00,
    RSN_INTR  = 2'b01,
    RSN_FAULT = 2'b10,
    RSN_INVAL = 2'b11
  } wake_rsn_e;

  typedef enum logic [1:0] {
    MON_OFF   = 2'b00,
    MON_ARMED = 2'b01,
    MON_TRIG  = 2'b10
  } mon_state_e;

  // Largest power of two not above v (0 stays 0).
  function automatic logic [31:0] floor_pow2(input logic [31:0] v);
    logic [31:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) p = 32'd1 << i;
    end
    return p;
  endfunction

  // Clamp a requested granule into [lo, hi]; lo and hi are powers of two.
  function automatic logic [31:0] clamp_line(input logic [31:0] req,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return floor_pow2(req);
  endfunction

  // Address mask that keeps the bits above a power-of-two granule.
  function automatic logic [31:0] line_mask(input logic [31:0] sz);
    return ~(sz - 32'd1);
  endfunction

  // Wake reason priority while stalled; invalidate is the fallback.
  function automatic wake_rsn_e pick_reason(input logic wr,
                                            input logic flt,
                                            input logic irq);
    if (wr)  return RSN_WRITE;
    if (flt) return RSN_FAULT;
    if (irq) return RSN_INTR;
    return RSN_INVAL;
  endfunction

endpackage

// File: rtl/awu_line_reg.sv
module awu_line_reg
  import awu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LW       = 16,
  parameter int MIN_LINE = 64,
  parameter int MAX_LINE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_data,
  output logic [LW-1:0] line_size,
  output logic [AW-1:0] addr_mask
);

  logic [LW-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= LW'(MIN_LINE);
    end else if (wr_en) begin
      line_q <= LW'(clamp_line(32'(wr_data), 32'(MIN_LINE), 32'(MAX_LINE)));
    end
  end

  assign line_size = line_q;
  assign addr_mask = AW'(line_mask(32'(line_q)));

endmodule

// File: rtl/awu_snoop_match.sv
module awu_snoop_match #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] addr_mask,
  input  logic          snp_valid,
  input  logic          snp_wb,
  input  logic [AW-1:0] snp_addr,
  output logic          hit
);

  logic [AW-1:0] watch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watch_q <= '0;
    end else if (load) begin
      watch_q <= load_addr;
    end
  end

  // Only write-back stores inside the same granule count.
  assign hit = snp_valid && snp_wb &&
               ((snp_addr & addr_mask) == (watch_q & addr_mask));

endmodule

// File: rtl/awu_wait_ctrl.sv
module awu_wait_ctrl
  import awu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_ok,
  input  logic       arm_valid,
  input  logic       arm_wb,
  input  logic       wait_valid,
  input  logic       snoop_hit,
  input  logic       ev_intr,
  input  logic       ev_fault,
  input  logic       ev_inval,
  output logic       arm_load,
  output logic       armed_hit,
  output logic       stall,
  output logic       wake_pulse,
  output logic [1:0] wake_rsn,
  output logic       cmd_fault
);

  mon_state_e mon_q;
  wake_rsn_e  trig_q;
  wake_rsn_e  rsn_q;
  logic       wait_q;
  logic       wake_q;
  logic       flt_q;

  logic       arm_go;
  logic       wait_go;
  logic       bad_cmd;
  logic       arm_trig;
  logic       wake_any;
  wake_rsn_e  wake_sel;
  wake_rsn_e  idle_sel;

  assign armed_hit = (mon_q == MON_ARMED) && snoop_hit;
  assign arm_trig  = (mon_q == MON_ARMED) && (snoop_hit || ev_inval);
  assign arm_go    = !wait_q && arm_valid && cmd_ok;
  assign wait_go   = !wait_q && wait_valid && cmd_ok && !arm_valid;
  assign bad_cmd   = !wait_q && !cmd_ok && (arm_valid || wait_valid);
  assign arm_load  = arm_go && arm_wb;
  assign wake_any  = armed_hit || ev_fault || ev_intr || ev_inval;
  assign wake_sel  = pick_reason(armed_hit, ev_fault, ev_intr);
  assign idle_sel  = snoop_hit ? RSN_WRITE : RSN_INVAL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_q  <= MON_OFF;
      trig_q <= RSN_WRITE;
      rsn_q  <= RSN_WRITE;
      wait_q <= 1'b0;
      wake_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      flt_q  <= bad_cmd;
      wake_q <= 1'b0;
      if (wait_q) begin
        if (wake_any) begin
          wait_q <= 1'b0;
          wake_q <= 1'b1;
          rsn_q  <= wake_sel;
          mon_q  <= MON_TRIG;
          trig_q <= wake_sel;
        end
      end else if (arm_go) begin
        mon_q <= arm_wb ? MON_ARMED : MON_OFF;
      end else begin
        if (arm_trig) begin
          mon_q  <= MON_TRIG;
          trig_q <= idle_sel;
        end
        if (wait_go) begin
          if (mon_q == MON_TRIG) begin
            wake_q <= 1'b1;
            rsn_q  <= trig_q;
          end else if (arm_trig) begin
            wake_q <= 1'b1;
            rsn_q  <= idle_sel;
          end else begin
            wait_q <= 1'b1;
          end
        end
      end
    end
  end

  assign stall      = wait_q;
  assign wake_pulse = wake_q;
  assign wake_rsn   = rsn_q;
  assign cmd_fault  = flt_q;

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LW       = 16,
  parameter int PLW      = 2,
  parameter int MIN_LINE = 64,
  parameter int MAX_LINE = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PLW-1:0] cpl,
  input  logic           arm_valid,
  input  logic [AW-1:0]  arm_addr,
  input  logic           arm_wb,
  input  logic           wait_valid,
  input  logic           snp_valid,
  input  logic [AW-1:0]  snp_addr,
  input  logic           snp_wb,
  input  logic           ev_intr,
  input  logic           ev_fault,
  input  logic           ev_inval,
  input  logic           ev_pwr,
  input  logic           gran_wr,
  input  logic [LW-1:0]  gran_wdata,
  output logic [LW-1:0]  gran_size,
  output logic [LW-1:0]  gran_min,
  output logic [LW-1:0]  gran_max,
  output logic           stall,
  output logic           wake_pulse,
  output logic [1:0]     wake_reason,
  output logic           cmd_fault
);

  logic          cmd_ok;
  logic          arm_load;
  logic          snoop_hit;
  logic          watch_hit;
  logic [AW-1:0] addr_mask;

  assign cmd_ok   = (cpl == '0);
  assign gran_min = LW'(MIN_LINE);
  assign gran_max = LW'(MAX_LINE);

  awu_line_reg #(
    .AW(AW), .LW(LW), .MIN_LINE(MIN_LINE), .MAX_LINE(MAX_LINE)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .wr_en(gran_wr), .wr_data(gran_wdata),
    .line_size(gran_size), .addr_mask(addr_mask)
  );

  awu_snoop_match #(.AW(AW)) u_match (
    .clk(clk), .rst_n(rst_n), .load(arm_load), .load_addr(arm_addr),
    .addr_mask(addr_mask), .snp_valid(snp_valid), .snp_wb(snp_wb),
    .snp_addr(snp_addr), .hit(snoop_hit)
  );

  awu_wait_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_ok(cmd_ok), .arm_valid(arm_valid),
    .arm_wb(arm_wb), .wait_valid(wait_valid), .snoop_hit(snoop_hit),
    .ev_intr(ev_intr), .ev_fault(ev_fault), .ev_inval(ev_inval),
    .arm_load(arm_load), .armed_hit(watch_hit), .stall(stall),
    .wake_pulse(wake_pulse), .wake_rsn(wake_reason), .cmd_fault(cmd_fault)
  );

endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
  parameter int LW  = 16,
  parameter int PLW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PLW-1:0] cpl,
  input logic           arm_valid,
  input logic           wait_valid,
  input logic           ev_intr,
  input logic           ev_fault,
  input logic           ev_inval,
  input logic           ev_pwr,
  input logic           watch_hit,
  input logic [LW-1:0]  gran_size,
  input logic [LW-1:0]  gran_min,
  input logic [LW-1:0]  gran_max,
  input logic           stall,
  input logic           wake_pulse,
  input logic [1:0]     wake_reason,
  input logic           cmd_fault
);

  assert_priv_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (cpl != '0) && (arm_valid || wait_valid)) |=> (cmd_fault && !wake_pulse));

  assert_stall_from_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(wait_valid));

  assert_write_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && watch_hit) |=> (wake_pulse && wake_reason == 2'b00));

  assert_event_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (ev_intr || ev_fault || ev_inval)) |=> (wake_pulse && !stall));

  assert_pwr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ev_pwr && !watch_hit && !ev_intr && !ev_fault && !ev_inval) |=> stall);

  assert_gran_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gran_size) == 1) && (gran_size >= gran_min) && (gran_size <= gran_max));

  assert_wake_not_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !stall);

endmodule

bind addr_watch_unit awu_checker #(.LW(LW), .PLW(PLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl(cpl), .arm_valid(arm_valid),
  .wait_valid(wait_valid), .ev_intr(ev_intr), .ev_fault(ev_fault),
  .ev_inval(ev_inval), .ev_pwr(ev_pwr), .watch_hit(watch_hit),
  .gran_size(gran_size), .gran_min(gran_min), .gran_max(gran_max),
  .stall(stall), .wake_pulse(wake_pulse), .wake_reason(wake_reason),
  .cmd_fault(cmd_fault)
);

// File: tb/addr_watch_unit_test.sv
module addr_watch_unit_test;

  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cpl = '0;
  logic          arm_valid = 1'b0;
  logic [AW-1:0] arm_addr = '0;
  logic          arm_wb = 1'b0;
  logic          wait_valid = 1'b0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_wb = 1'b0;
  logic          ev_intr = 1'b0;
  logic          ev_fault = 1'b0;
  logic          ev_inval = 1'b0;
  logic          ev_pwr = 1'b0;
  logic          gran_wr = 1'b0;
  logic [LW-1:0] gran_wdata = '0;
  logic [LW-1:0] gran_size, gran_min, gran_max;
  logic          stall, wake_pulse, cmd_fault;
  logic [1:0]    wake_reason;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  localparam logic [AW-1:0] A = 32'h0000_1000;

  always #10 clk = ~clk;

  addr_watch_unit uut (
    .clk(clk), .rst_n(rst_n), .cpl(cpl), .arm_valid(arm_valid),
    .arm_addr(arm_addr), .arm_wb(arm_wb), .wait_valid(wait_valid),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_wb(snp_wb),
    .ev_intr(ev_intr), .ev_fault(ev_fault), .ev_inval(ev_inval),
    .ev_pwr(ev_pwr), .gran_wr(gran_wr), .gran_wdata(gran_wdata),
    .gran_size(gran_size), .gran_min(gran_min), .gran_max(gran_max),
    .stall(stall), .wake_pulse(wake_pulse), .wake_reason(wake_reason),
    .cmd_fault(cmd_fault)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_wake(input logic [1:0] rsn, input string tag);
    exp_q.push_back(rsn);
    tag_q.push_back(tag);
  endtask

  task automatic do_arm(input logic [AW-1:0] a, input logic wb);
    arm_valid = 1'b1; arm_addr = a; arm_wb = wb;
    step();
    arm_valid = 1'b0; arm_wb = 1'b0;
  endtask

  task automatic do_wait();
    wait_valid = 1'b1;
    step();
    wait_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, input logic wb);
    snp_valid = 1'b1; snp_addr = a; snp_wb = wb;
    step();
    snp_valid = 1'b0; snp_wb = 1'b0;
  endtask

  task automatic do_gran(input logic [LW-1:0] v);
    gran_wr = 1'b1; gran_wdata = v;
    step();
    gran_wr = 1'b0;
  endtask

  // Scoreboard monitor: each wake pulse must match the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && wake_pulse) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected wake", 32'(wake_reason), 32'hFFFF);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(wake_reason == e, t, 32'(wake_reason), 32'(e));
        chk(stall == 1'b0, {t, " stall low at wake"}, 32'(stall), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // Reset state, R11
    chk(stall == 0, "R2 reset stall", 32'(stall), 0);
    chk(wake_pulse == 0, "R5 reset wake", 32'(wake_pulse), 0);
    chk(cmd_fault == 0, "R1 reset fault", 32'(cmd_fault), 0);
    chk(gran_size == 16'd64, "R11 reset granule", 32'(gran_size), 64);
    chk(gran_min == 16'd64, "R11 gran_min", 32'(gran_min), 64);
    chk(gran_max == 16'd128, "R11 gran_max", 32'(gran_max), 128);

    // Fire the watch, then refused commands must not disturb it (R1)
    do_arm(A, 1'b1);
    do_snoop(A + 32'h10, 1'b1);
    cpl = 2'd1;
    do_arm(A + 32'h400, 1'b1);
    chk(cmd_fault == 1, "R1 arm at level 1", 32'(cmd_fault), 1);
    cpl = 2'd2;
    do_wait();
    chk(cmd_fault == 1, "R1 wait at level 2", 32'(cmd_fault), 1);
    chk(stall == 0, "R1 refused wait no stall", 32'(stall), 0);
    cpl = 2'd0;
    step();
    chk(cmd_fault == 0, "R1 fault is one cycle", 32'(cmd_fault), 0);

    // Already fired: wait is a no-op (R5), and again without re-arm (R6)
    expect_wake(2'b00, "R5 immediate wake");
    do_wait();
    chk(stall == 0, "R5 no stall", 32'(stall), 0);
    expect_wake(2'b00, "R6 no re-arm");
    do_wait();
    chk(stall == 0, "R6 no stall", 32'(stall), 0);

    // Armed wait and snoop filtering (R2, R4)
    do_arm(A, 1'b1);
    do_wait();
    chk(stall == 1, "R2 stall after wait", 32'(stall), 1);
    do_snoop(A, 1'b0);
    chk(stall == 1, "R4 non-write-back ignored", 32'(stall), 1);
    do_snoop(A + 32'd64, 1'b1);
    chk(stall == 1, "R4 outside granule ignored", 32'(stall), 1);
    expect_wake(2'b00, "R4 monitored write");
    do_snoop(A + 32'd63, 1'b1);
    chk(stall == 0, "R4 stall released", 32'(stall), 0);

    // Commands ignored while stalled (R12)
    do_arm(A, 1'b1);
    do_wait();
    do_arm(A, 1'b0);
    cpl = 2'd3;
    do_wait();
    chk(cmd_fault == 0, "R12 no fault while stalled", 32'(cmd_fault), 0);
    cpl = 2'd0;
    chk(stall == 1, "R12 still stalled", 32'(stall), 1);
    expect_wake(2'b00, "R12 watch kept armed");
    do_snoop(A, 1'b1);

    // Power events ignored (R9), then interrupt wake (R7)
    do_arm(A, 1'b1);
    do_wait();
    ev_pwr = 1'b1;
    step(); step(); step();
    ev_pwr = 1'b0;
    chk(stall == 1, "R9 power event no wake", 32'(stall), 1);
    expect_wake(2'b01, "R7 interrupt");
    ev_intr = 1'b1; step(); ev_intr = 1'b0;
    chk(stall == 0, "R7 interrupt releases", 32'(stall), 0);

    do_arm(A, 1'b1);
    do_snoop(A, 1'b1);
    ev_pwr = 1'b1; step(); ev_pwr = 1'b0;
    expect_wake(2'b00, "R9 trigger kept after power event");
    do_wait();
    chk(stall == 0, "R9 wait still a no-op", 32'(stall), 0);

    // Fault wake (R7)
    do_arm(A, 1'b1);
    do_wait();
    expect_wake(2'b10, "R7 fault");
    ev_fault = 1'b1; step(); ev_fault = 1'b0;

    // Invalidate wake, and invalidate while armed before wait (R8)
    do_arm(A, 1'b1);
    do_wait();
    expect_wake(2'b11, "R8 invalidate while stalled");
    ev_inval = 1'b1; step(); ev_inval = 1'b0;
    do_arm(A, 1'b1);
    ev_inval = 1'b1; step(); ev_inval = 1'b0;
    expect_wake(2'b11, "R8 invalidate fired watch");
    do_wait();
    chk(stall == 0, "R8 no stall after invalidate", 32'(stall), 0);

    // Non-write-back arm leaves watch off (R3)
    do_arm(A, 1'b0);
    do_snoop(A, 1'b1);
    do_wait();
    chk(stall == 1, "R3 unarmed wait stalls", 32'(stall), 1);
    do_snoop(A, 1'b1);
    chk(stall == 1, "R3 write ignored when unarmed", 32'(stall), 1);
    expect_wake(2'b01, "R3 released by interrupt");
    ev_intr = 1'b1; step(); ev_intr = 1'b0;

    // Priority among coincident sources (R10)
    do_arm(A, 1'b1);
    do_wait();
    expect_wake(2'b00, "R10 write beats all");
    snp_valid = 1'b1; snp_addr = A; snp_wb = 1'b1;
    ev_fault = 1'b1; ev_intr = 1'b1; ev_inval = 1'b1;
    step();
    snp_valid = 1'b0; snp_wb = 1'b0; ev_fault = 1'b0; ev_intr = 1'b0; ev_inval = 1'b0;
    do_arm(A, 1'b1);
    do_wait();
    expect_wake(2'b10, "R10 fault beats interrupt");
    ev_fault = 1'b1; ev_intr = 1'b1; ev_inval = 1'b1;
    step();
    ev_fault = 1'b0; ev_intr = 1'b0; ev_inval = 1'b0;
    do_arm(A, 1'b1);
    do_wait();
    expect_wake(2'b01, "R10 interrupt beats invalidate");
    ev_intr = 1'b1; ev_inval = 1'b1;
    step();
    ev_intr = 1'b0; ev_inval = 1'b0;

    // Granule register clamping and use (R11)
    do_gran(16'd100);
    chk(gran_size == 16'd64, "R11 round down 100", 32'(gran_size), 64);
    do_gran(16'd1000);
    chk(gran_size == 16'd128, "R11 clamp high", 32'(gran_size), 128);
    do_gran(16'd8);
    chk(gran_size == 16'd64, "R11 clamp low", 32'(gran_size), 64);
    do_gran(16'd128);
    chk(gran_size == 16'd128, "R11 exact 128", 32'(gran_size), 128);
    do_arm(32'h0000_2000, 1'b1);
    do_wait();
    expect_wake(2'b00, "R11 match over 128-byte granule");
    do_snoop(32'h0000_2040, 1'b1);
    chk(stall == 0, "R11 wide granule hit", 32'(stall), 0);

    step(); step();
    chk(exp_q.size() == 0, "all expected wakes seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule